// File: doc/BRIEF.md
# Halfword Fetch Realigner

This block sits between an aligned 32-bit instruction fetch port and the decoder of a processor whose instruction set mixes 16-bit and 32-bit encodings. Fetch words arrive with their word address. The block cuts each word into two 16-bit parcels and keeps them in a three-parcel holding buffer. On each cycle it hands the decoder one whole instruction, together with its program counter and a flag telling a 16-bit instruction from a 32-bit one. A 32-bit instruction may start in the upper half of one fetch word. The buffer then keeps that half until the next word arrives, so no word is ever fetched twice.

The length of each instruction is decided from its first parcel only. A redirect input with a target address empties the buffer and the output stage. After a redirect the block discards every fetch word that does not belong to the target's word address. If the target sits on the upper halfword, the lower half of the target word is dropped. The fetch side is a valid/ready pair and so is the decoder side. Encodings longer than 32 bits are not realigned. Their first parcel is passed on alone with an illegal flag.

Top module: `fetch_aligner`

## Requirements
- R1: A parcel whose bits [1:0] are not 2'b11 is a 16-bit instruction. It is emitted with out_compressed=1 and out_illegal=0, out_instr[15:0] holds the parcel and out_instr[31:16] is zero.
- R2: A parcel with bits [1:0]=2'b11 and bits [4:2] not equal to 3'b111 starts a 32-bit instruction. It is emitted with out_compressed=0 and out_illegal=0, and out_instr is {second parcel, first parcel}.
- R3: A parcel with bits [4:0]=5'b11111 is emitted alone with out_illegal=1, out_compressed=0 and out_instr[31:16] zero. Only that one parcel is used up.
- R4: A 32-bit instruction whose first parcel is the upper half of one fetch word is completed from the lower half of the next word. Each fetch word is accepted exactly once, and every instruction of a sequential stream is delivered.
- R5: Two 16-bit instructions from one fetch word come out oldest first, on consecutive cycles while out_ready is high. fetch_ready is low whenever taking a word would leave more than three parcels buffered.
- R6: The PC of each delivered instruction is the previous PC plus 2 after a 16-bit or illegal parcel, and plus 4 after a 32-bit instruction.
- R7: During a cycle with redirect_valid high, fetch_ready is low. In the following cycle out_valid is low, and every parcel buffered before the redirect is dropped.
- R8: The first instruction delivered after a redirect has out_pc equal to the target. When target bit 1 is set, the lower halfword of the target's fetch word is dropped.
- R9: After a redirect, fetch words whose fetch_addr differs from the target's word-aligned address are accepted and discarded until the matching word arrives.
- R10: While out_valid is high and out_ready is low, out_valid, out_instr and out_pc keep their values (unless a redirect flushes them).
- R11: After reset, out_valid is 0, fetch_ready is 1 and the buffer is empty.
- R12: When the output stage is free, the first instruction of a word accepted at one clock edge is presented on the output after the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_valid | input | 1 | Fetch word present |
| fetch_ready | output | 1 | Block takes the fetch word this cycle |
| fetch_word | input | 32 | Aligned fetch data, lower address in bits [15:0] |
| fetch_addr | input | AW | Byte address of the fetch word (word aligned) |
| redirect_valid | input | 1 | Restart the stream at redirect_pc |
| redirect_pc | input | AW | Halfword-aligned redirect target |
| out_valid | output | 1 | Instruction present on the output |
| out_ready | input | 1 | Decoder takes the instruction this cycle |
| out_instr | output | 32 | Instruction bits, upper half zero when not 32-bit |
| out_pc | output | AW | Address of the instruction |
| out_compressed | output | 1 | Instruction is 16 bits long |
| out_illegal | output | 1 | First parcel marks an encoding longer than 32 bits |

## Verification
The fetch word taken at one edge fills the buffer. Its first instruction is loaded into the output register at the next edge. The bench samples both sides at falling edges, so it expects a gap of exactly two samples between the first accepted word and the first delivered instruction. A redirect sampled at one edge must show fetch_ready low in that same cycle and out_valid low at the following sample. The bench drives every input one time unit after the rising edge and reads every result at the falling edge, so each handshake it logs is the one the design sees at the next edge. A scoreboard holds the expected instruction, PC and kind for each parcel the bench lays into its fetch memory, and compares them in order as deliveries happen, with the decoder ready signal held high, toggled pseudo-randomly, or held low.

// File: rtl/fa_pkg.sv
package fa_pkg;
  localparam int PARCEL_W = 16;

  typedef logic [PARCEL_W-1:0] parcel_t;

  typedef enum logic [1:0] {
    LEN_HALF = 2'd0,
    LEN_FULL = 2'd1,
    LEN_LONG = 2'd2
  } len_e;

  // Length is decided from the lowest-addressed parcel alone.
  function automatic len_e parcel_len(parcel_t p);
    if (p[1:0] != 2'b11) return LEN_HALF;
    if (p[4:2] != 3'b111) return LEN_FULL;
    return LEN_LONG;
  endfunction
endpackage

// File: rtl/fa_len_decode.sv
module fa_len_decode
  import fa_pkg::*;
(
  input  parcel_t first_parcel,
  output len_e    len
);
  assign len = parcel_len(first_parcel);
endmodule

// File: rtl/fa_parcel_queue.sv
module fa_parcel_queue
  import fa_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DEPTH = 3,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  flush,
  input  logic [1:0]            pop_n,
  input  logic [1:0]            push_n,
  input  parcel_t [1:0]         push_bits,
  input  logic [1:0][AW-1:0]    push_pc,
  output logic [CW-1:0]         cnt,
  output parcel_t [1:0]         head_bits,
  output logic [1:0][AW-1:0]    head_pc
);
  parcel_t       qb [DEPTH];
  logic [AW-1:0] qp [DEPTH];
  parcel_t       nb [DEPTH];
  logic [AW-1:0] np [DEPTH];
  logic [CW-1:0] cnt_q, rem, cnt_n;

  always_comb begin
    rem   = cnt_q - CW'(pop_n);
    cnt_n = rem + CW'(push_n);
    for (int i = 0; i < DEPTH; i++) begin
      int src;
      int j;
      src   = i + int'(pop_n);
      j     = i - int'(rem);
      nb[i] = qb[i];
      np[i] = qp[i];
      if (i < int'(rem)) begin
        for (int k = 0; k < DEPTH; k++) begin
          if (k == src) begin
            nb[i] = qb[k];
            np[i] = qp[k];
          end
        end
      end else if (j < int'(push_n)) begin
        if (j == 0) begin
          nb[i] = push_bits[0];
          np[i] = push_pc[0];
        end else begin
          nb[i] = push_bits[1];
          np[i] = push_pc[1];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_n;
    end
    for (int i = 0; i < DEPTH; i++) begin
      if (rst) begin
        qb[i] <= '0;
        qp[i] <= '0;
      end else begin
        qb[i] <= nb[i];
        qp[i] <= np[i];
      end
    end
  end

  assign cnt          = cnt_q;
  assign head_bits[0] = qb[0];
  assign head_bits[1] = qb[1];
  assign head_pc[0]   = qp[0];
  assign head_pc[1]   = qp[1];
endmodule

// File: rtl/fa_out_reg.sv
module fa_out_reg #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          advance,
  input  logic          load,
  input  logic [31:0]   in_instr,
  input  logic [AW-1:0] in_pc,
  input  logic          in_comp,
  input  logic          in_ill,
  output logic          valid,
  output logic [31:0]   instr,
  output logic [AW-1:0] pc,
  output logic          comp,
  output logic          ill
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      instr <= '0;
      pc    <= '0;
      comp  <= 1'b0;
      ill   <= 1'b0;
    end else if (flush) begin
      valid <= 1'b0;
    end else if (advance) begin
      valid <= load;
      if (load) begin
        instr <= in_instr;
        pc    <= in_pc;
        comp  <= in_comp;
        ill   <= in_ill;
      end
    end
  end
endmodule

// File: rtl/fetch_aligner.sv
module fetch_aligner
  import fa_pkg::*;
#(
  parameter int AW     = 32,
  parameter int QDEPTH = 3,
  localparam int CW    = $clog2(QDEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fetch_valid,
  output logic          fetch_ready,
  input  logic [31:0]   fetch_word,
  input  logic [AW-1:0] fetch_addr,
  input  logic          redirect_valid,
  input  logic [AW-1:0] redirect_pc,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [31:0]   out_instr,
  output logic [AW-1:0] out_pc,
  output logic          out_compressed,
  output logic          out_illegal
);
  logic [CW-1:0]      cnt, rem;
  parcel_t [1:0]      hb;
  logic [1:0][AW-1:0] hp;
  parcel_t [1:0]      pb;
  logic [1:0][AW-1:0] pp;
  logic [1:0]         pop_n, push_n;
  len_e               len;
  logic               advance, emit, take, match, skip;
  logic               waiting_q;
  logic [AW-1:0]      tgt_q;
  logic [31:0]        nxt_instr;

  fa_len_decode u_len (.first_parcel(hb[0]), .len(len));

  always_comb begin
    advance = !out_valid || out_ready;
    emit    = !redirect_valid && advance && (cnt != '0) &&
              ((len != LEN_FULL) || (cnt >= CW'(2)));
    pop_n   = !emit ? 2'd0 : (len == LEN_FULL) ? 2'd2 : 2'd1;
    rem     = cnt - CW'(pop_n);
    fetch_ready = !redirect_valid && (rem <= CW'(QDEPTH - 2));
    take    = fetch_valid && fetch_ready;
    match   = fetch_addr == {tgt_q[AW-1:2], 2'b00};
    skip    = waiting_q && (tgt_q[1:0] != 2'b00);
    if (!take || (waiting_q && !match)) push_n = 2'd0;
    else if (skip)                      push_n = 2'd1;
    else                                push_n = 2'd2;
    pb[0] = skip ? fetch_word[31:16] : fetch_word[15:0];
    pp[0] = skip ? fetch_addr + AW'(2) : fetch_addr;
    pb[1] = fetch_word[31:16];
    pp[1] = fetch_addr + AW'(2);
    nxt_instr = (len == LEN_FULL) ? {hb[1], hb[0]} : {16'h0000, hb[0]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      waiting_q <= 1'b0;
      tgt_q     <= '0;
    end else if (redirect_valid) begin
      waiting_q <= 1'b1;
      tgt_q     <= redirect_pc;
    end else if (take && match) begin
      waiting_q <= 1'b0;
    end
  end

  fa_parcel_queue #(.AW(AW), .DEPTH(QDEPTH)) u_queue (
    .clk(clk), .rst(rst), .flush(redirect_valid),
    .pop_n(pop_n), .push_n(push_n), .push_bits(pb), .push_pc(pp),
    .cnt(cnt), .head_bits(hb), .head_pc(hp)
  );

  fa_out_reg #(.AW(AW)) u_out (
    .clk(clk), .rst(rst), .flush(redirect_valid), .advance(advance),
    .load(emit), .in_instr(nxt_instr), .in_pc(hp[0]),
    .in_comp(len == LEN_HALF), .in_ill(len == LEN_LONG),
    .valid(out_valid), .instr(out_instr), .pc(out_pc),
    .comp(out_compressed), .ill(out_illegal)
  );
endmodule

// File: rtl/fetch_aligner_chk.sv
module fetch_aligner_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          fetch_ready,
  input logic          redirect_valid,
  input logic [AW-1:0] redirect_pc,
  input logic          out_valid,
  input logic          out_ready,
  input logic [31:0]   out_instr,
  input logic [AW-1:0] out_pc,
  input logic          out_compressed,
  input logic          out_illegal
);
  logic          seen_q;
  logic [AW-1:0] exp_pc_q;
  logic          fire;

  assign fire = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_q   <= 1'b0;
      exp_pc_q <= '0;
    end else if (redirect_valid) begin
      seen_q   <= 1'b1;
      exp_pc_q <= redirect_pc;
    end else if (fire) begin
      seen_q   <= 1'b1;
      exp_pc_q <= out_pc + ((!out_compressed && !out_illegal) ? AW'(4) : AW'(2));
    end
  end

  AST_HALF_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_compressed |-> out_instr[31:16] == 16'h0 && out_instr[1:0] != 2'b11); // R1
  AST_FULL_CODE: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_compressed && !out_illegal |-> out_instr[1:0] == 2'b11 && out_instr[4:2] != 3'b111); // R2
  AST_LONG_FLAG: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_illegal |-> out_instr[4:0] == 5'h1f && !out_compressed && out_instr[31:16] == 16'h0); // R3
  AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
    fire && seen_q |-> out_pc == exp_pc_q); // R6
  AST_REDIRECT_NO_TAKE: assert property (@(posedge clk) disable iff (rst)
    redirect_valid |-> !fetch_ready); // R7
  AST_REDIRECT_FLUSH: assert property (@(posedge clk) disable iff (rst)
    redirect_valid |=> !out_valid); // R7
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready && !redirect_valid |=> out_valid && $stable(out_instr) && $stable(out_pc)); // R10
endmodule

bind fetch_aligner fetch_aligner_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .fetch_ready(fetch_ready),
  .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
  .out_valid(out_valid), .out_ready(out_ready), .out_instr(out_instr),
  .out_pc(out_pc), .out_compressed(out_compressed), .out_illegal(out_illegal)
);

// File: tb/tb_fetch_aligner.sv
module tb_fetch_aligner;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int STALE = 'hC0;

  logic clk = 0, rst = 1;
  logic fetch_valid = 0, fetch_ready;
  logic [31:0] fetch_word = 0;
  logic [AW-1:0] fetch_addr = 0;
  logic redirect_valid = 0;
  logic [AW-1:0] redirect_pc = 0;
  logic out_valid, out_ready = 1;
  logic [31:0] out_instr;
  logic [AW-1:0] out_pc;
  logic out_compressed, out_illegal;

  fetch_aligner #(.AW(AW)) dut (
    .clk(clk), .rst(rst), .fetch_valid(fetch_valid), .fetch_ready(fetch_ready),
    .fetch_word(fetch_word), .fetch_addr(fetch_addr),
    .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
    .out_valid(out_valid), .out_ready(out_ready), .out_instr(out_instr),
    .out_pc(out_pc), .out_compressed(out_compressed), .out_illegal(out_illegal)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  typedef struct {
    logic [AW-1:0] pc;
    logic [31:0]   instr;
    bit            c;
    bit            ill;
    string         tag;
  } exp_t;

  exp_t expq[$];
  logic [15:0] mem [0:255];
  int pop_cyc [0:255];
  int errors = 0, checks = 0, cyc = 0, ptr = 0;
  int f_addr = 0, f_lim = 0, f_after = -1, first_acc_cyc = -1, stall_seen = 0;
  bit inject_stale = 0, rdy_mode = 0, rdy_force = 1;
  logic [15:0] lfsr = 16'hACE1;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic put_c(input int k, input bit keep);
    logic [15:0] v;
    v = 16'(k * 1156) & 16'hFFFC;
    v[1:0] = 2'(k % 3);
    mem[ptr >> 1] = v;
    if (keep) expq.push_back('{AW'(ptr), {16'h0, v}, 1'b1, 1'b0, "R1"});
    ptr += 2;
  endtask

  task automatic put_f(input int k, input bit keep);
    logic [31:0] v;
    v = 32'(k * 32'h9E3779B1);
    v[1:0] = 2'b11;
    v[4:2] = 3'(k % 7);
    mem[ptr >> 1] = v[15:0];
    mem[(ptr >> 1) + 1] = v[31:16];
    if (keep) expq.push_back('{AW'(ptr), v, 1'b0, 1'b0, (ptr % 4 == 2) ? "R4" : "R2"});
    ptr += 4;
  endtask

  task automatic put_ill(input int k, input bit keep);
    logic [15:0] v;
    v = 16'(k * 1156);
    v[4:0] = 5'h1f;
    mem[ptr >> 1] = v;
    if (keep) expq.push_back('{AW'(ptr), {16'h0, v}, 1'b0, 1'b1, "R3"});
    ptr += 2;
  endtask

  task automatic drain();
    int n = 0;
    while (expq.size() != 0 && n < 2000) begin
      @(negedge clk);
      n++;
    end
    chk(expq.size() == 0, "R4", "stream fully delivered, items left", expq.size(), 0);
    repeat (6) @(negedge clk);
  endtask

  task automatic do_redirect(input int tgt);
    @(posedge clk); #1;
    redirect_valid = 1;
    redirect_pc = AW'(tgt);
    @(negedge clk);
    chk(!fetch_ready, "R7", "fetch_ready during redirect", fetch_ready, 0);
    @(posedge clk); #1;
    redirect_valid = 0;
    @(negedge clk);
    chk(!out_valid, "R7", "out_valid after redirect", out_valid, 0);
  endtask

  // Fetch port model: one word per accepted handshake.
  initial begin
    bit acc, rd;
    int rd_pc;
    forever begin
      @(negedge clk);
      acc = fetch_valid && fetch_ready;
      rd = redirect_valid;
      rd_pc = int'(redirect_pc);
      if (acc && first_acc_cyc < 0) first_acc_cyc = cyc;
      if (fetch_valid && !fetch_ready && !redirect_valid) stall_seen++;
      @(posedge clk); #1;
      if (rd) begin
        if (inject_stale) begin
          f_addr = STALE;
          f_after = rd_pc & ~3;
        end else begin
          f_addr = rd_pc & ~3;
        end
      end else if (acc) begin
        if (f_after >= 0) begin
          f_addr = f_after;
          f_after = -1;
        end else begin
          f_addr += 4;
        end
      end
      fetch_valid = (f_addr < f_lim) || (f_after >= 0);
      fetch_addr = AW'(f_addr);
      fetch_word = {mem[(f_addr >> 1) + 1], mem[f_addr >> 1]};
    end
  end

  // Decoder ready model.
  initial begin
    forever begin
      @(posedge clk); #1;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      out_ready = rdy_mode ? lfsr[0] : rdy_force;
    end
  end

  // Monitor and scoreboard.
  initial begin
    bit prev_hold = 0;
    logic [31:0] h_i;
    logic [AW-1:0] h_pc;
    exp_t e;
    forever begin
      @(negedge clk);
      if (!rst) begin
        if (prev_hold)
          chk(out_valid && out_instr == h_i && out_pc == h_pc, "R10",
              "held output changed, pc", out_pc, h_pc);
        if (out_valid && out_ready) begin
          if (out_pc < 512) pop_cyc[out_pc >> 1] = cyc;
          if (expq.size() == 0) begin
            chk(0, "R9", "unexpected output pc", out_pc, 0);
          end else begin
            e = expq.pop_front();
            chk(out_pc == e.pc, "R6", "pc", out_pc, e.pc);
            chk(out_instr == e.instr, e.tag, "instr", out_instr, e.instr);
            chk(out_compressed == e.c && out_illegal == e.ill, e.tag, "kind {c,ill}",
                {out_compressed, out_illegal}, {e.c, e.ill});
          end
        end
        prev_hold = out_valid && !out_ready && !redirect_valid;
        h_i = out_instr;
        h_pc = out_pc;
      end
    end
  end

  initial begin
    repeat (60000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i] = 16'h0;
      pop_cyc[i] = -1;
    end
    repeat (4) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    chk(!out_valid, "R11", "out_valid after reset", out_valid, 0);
    chk(fetch_ready, "R11", "fetch_ready after reset", fetch_ready, 1);

    // Mixed stream from address 0, decoder always ready.
    ptr = 0;
    put_c(1, 1); put_c(2, 1); put_f(3, 1); put_c(4, 1);
    put_f(5, 1); put_f(6, 1); put_c(7, 1); put_c(8, 1); put_c(9, 1);
    for (int k = 10; k < 14; k++) put_c(k, 1);
    put_f(14, 1);
    f_lim = ptr;
    drain();
    chk(pop_cyc[1] - pop_cyc[0] == 1, "R5", "cycles between paired parcels",
        pop_cyc[1] - pop_cyc[0], 1);
    chk(stall_seen > 0, "R5", "fetch stalled on full buffer", stall_seen, 1);
    chk(pop_cyc[0] - first_acc_cyc == 2, "R12", "samples from accept to output",
        pop_cyc[0] - first_acc_cyc, 2);

    // Long encodings and back-pressure.
    @(negedge clk);
    rdy_mode = 1;
    put_f(20, 1); put_c(21, 1); put_ill(22, 1); put_c(23, 1); put_f(24, 1);
    put_ill(25, 1); put_f(26, 1); put_c(27, 1); put_f(28, 1); put_c(29, 1);
    f_lim = ptr;
    drain();
    @(negedge clk);
    rdy_mode = 0;
    rdy_force = 1;

    // Redirect to an aligned target with an empty buffer.
    ptr = 'h60;
    put_c(30, 1); put_f(31, 1); put_c(32, 1);
    f_lim = ptr;
    do_redirect('h60);
    drain();
    chk(pop_cyc['h30] >= 0, "R8", "aligned target delivered", pop_cyc['h30], 1);

    // Redirect while full and stalled: flush, stale word, upper-half target.
    ptr = 'h80;
    for (int k = 50; k < 54; k++) put_c(k, 0);
    @(negedge clk);
    rdy_force = 0;
    f_lim = ptr;
    do_redirect('h80);
    for (int n = 0; n < 20 && !out_valid; n++) @(negedge clk);
    chk(out_valid, "R10", "output waits under back-pressure", out_valid, 1);
    mem[STALE >> 1] = 16'h1234;
    mem[(STALE >> 1) + 1] = 16'h5678;
    ptr = 'h100;
    put_c(60, 0);
    put_f(40, 1); put_c(41, 1); put_c(42, 1); put_f(43, 1); put_ill(44, 1);
    f_lim = ptr;
    inject_stale = 1;
    do_redirect('h102);
    inject_stale = 0;
    @(negedge clk);
    rdy_force = 1;
    drain();
    chk(pop_cyc['h81] >= 0, "R8", "upper-half target delivered", pop_cyc['h81], 1);
    chk(pop_cyc['h80] < 0, "R8", "dropped lower half delivered", pop_cyc['h80], -1);
    chk(pop_cyc[STALE >> 1] < 0, "R9", "stale word delivered", pop_cyc[STALE >> 1], -1);
    chk(pop_cyc['h40] < 0, "R7", "flushed parcel delivered", pop_cyc['h40], -1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule